// File: doc/BRIEF.md
# Half-Rate to DDR Output Serializer

This block sits between core logic and a group of output pads. The core hands over a four-bit word per pad on every rising edge of a half-rate clock. The block turns each word into a double-data-rate stream on a full-rate clock that runs at exactly twice that frequency. A capture stage on the half-rate clock holds the word. A full-rate stage then drives two bits per full-rate cycle: one during the high phase and one during the low phase. A per-pad output enable is captured with the word and registered along the same path, so the tri-state control changes only at word boundaries and stays aligned with the data.

Two active-low asynchronous inputs act on the output registers and override every clock. One forces the pads low and the other forces them high, and the low-forcing input wins when both are asserted. Two other modes are picked by parameter. A full-rate DDR mode skips the half-rate stage and sends two bits per full-rate cycle. A single-rate register mode drives one bit for a whole full-rate cycle. The pad count is a parameter from 1 to 128. The high-impedance state itself is left to the pad driver, which receives a separate drive-enable output.

Top module: `ddr_out_serializer`

## Requirements
- R1: In half-rate mode the data input is laid out as four lanes of WIDTH bits: din[k*WIDTH+i] is bit k of pad i. A word captured at a rising half-rate edge T is driven with bit 0 in the high phase and bit 1 in the low phase of the full-rate cycle that starts at the first full-rate rising edge after T.
- R2: Bits 2 and 3 of that word follow in the high and low phases of the next full-rate cycle. Words captured on consecutive half-rate edges appear back to back, each exactly once.
- R3: The output enable is captured with the data word. The drive-enable output pad_oe carries it for all four bit times of that word and changes only when a new word starts.
- R4: While aclr_n is low, pad_o is all zeros at once, whatever the clocks, the data or apre_n.
- R5: While apre_n is low and aclr_n is high, pad_o is all ones at once. When both are low, clear wins and pad_o is zero.
- R6: A synchronous active-high rst drives pad_o and pad_oe to zero.
- R7: In full-rate mode, lanes 0 and 1 captured at a full-rate rising edge are driven in the high and low phases of the cycle that starts at that edge. The enable is updated at every such edge.
- R8: In single-rate mode, lane 0 captured at a full-rate rising edge is driven for the whole cycle that starts at that edge. Lanes 1 to 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_hr | input | 1 | Half-rate clock; captures words in half-rate mode |
| clk_fr | input | 1 | Full-rate clock, twice the half-rate frequency; both phases carry data |
| rst | input | 1 | Synchronous active-high reset |
| aclr_n | input | 1 | Asynchronous active-low force-to-zero of the output registers |
| apre_n | input | 1 | Asynchronous active-low force-to-one of the output registers |
| din | input | 4*WIDTH | Data word, lane k of pad i at bit k*WIDTH+i |
| oe | input | WIDTH | Per-pad output enable from the core |
| pad_o | output | WIDTH | DDR data toward the pads |
| pad_oe | output | WIDTH | Per-pad drive enable; low means the pad is released |

## Verification
In half-rate mode, a word captured at a half-rate edge T reaches the pad one full-rate edge later, at T+8 ns. Its four bits sit in the windows T+8, T+12, T+16 and T+20 ns, each 4 ns long. The enable covers T+8 to T+24 ns. The bench drives each word 2 ns after a half-rate edge. It samples every window at its midpoint, 2 ns inside and clear of both clock edges, so the tail of the previous word and the head of the current one are both checked in each half-rate period. Full-rate and single-rate results are due within the cycle that starts at the capturing edge and are sampled 2 ns into each phase. The asynchronous clear and preset are checked 1 ns after they change, with no clock edge in between, and again across later edges.

// File: rtl/ddr_out_pkg.sv
package ddr_out_pkg;
  typedef enum int unsigned {
    SER_HALF   = 0,
    SER_FULL   = 1,
    SER_SIMPLE = 2
  } ser_mode_e;

  localparam int LANES = 4;
endpackage

// File: rtl/ddr_out_hr_stage.sv
module ddr_out_hr_stage
  import ddr_out_pkg::*;
#(
  parameter int        WIDTH = 4,
  parameter ser_mode_e MODE  = SER_HALF
) (
  input  logic                     clk_hr,
  input  logic                     rst,
  input  logic [WIDTH*LANES-1:0]   din,
  input  logic [WIDTH-1:0]         oe_in,
  output logic [WIDTH*LANES-1:0]   word_q,
  output logic [WIDTH-1:0]         oe_q,
  output logic                     tog_q
);
  generate
    if (MODE == SER_HALF) begin : g_half
      always_ff @(posedge clk_hr) begin
        if (rst) begin
          word_q <= '0;
          oe_q   <= '0;
          tog_q  <= 1'b0;
        end else begin
          word_q <= din;
          oe_q   <= oe_in;
          tog_q  <= ~tog_q;
        end
      end
    end else begin : g_bypass
      logic unused_hr;
      assign word_q    = din;
      assign oe_q      = oe_in;
      assign tog_q     = 1'b0;
      assign unused_hr = clk_hr ^ rst;
    end
  endgenerate
endmodule

// File: rtl/ddr_out_fr_stage.sv
module ddr_out_fr_stage
  import ddr_out_pkg::*;
#(
  parameter int        WIDTH = 4,
  parameter ser_mode_e MODE  = SER_HALF
) (
  input  logic                   clk_fr,
  input  logic                   rst,
  input  logic                   aclr_n,
  input  logic                   apre_n,
  input  logic [WIDTH*LANES-1:0] word_i,
  input  logic                   tog_i,
  output logic [WIDTH-1:0]       hi_q,
  output logic [WIDTH-1:0]       lo_q,
  output logic                   new_word
);
  logic [WIDTH-1:0] b0, b1, b2, b3;
  logic [WIDTH-1:0] nxt_hi, nxt_lo, lo_pos;

  assign b0 = word_i[0*WIDTH +: WIDTH];
  assign b1 = word_i[1*WIDTH +: WIDTH];
  assign b2 = word_i[2*WIDTH +: WIDTH];
  assign b3 = word_i[3*WIDTH +: WIDTH];

  generate
    if (MODE == SER_HALF) begin : g_half
      logic seen;
      always_ff @(posedge clk_fr) begin
        if (rst) seen <= 1'b0;
        else     seen <= tog_i;
      end
      assign new_word = tog_i ^ seen;
      assign nxt_hi   = new_word ? b0 : b2;
      assign nxt_lo   = new_word ? b1 : b3;

      // R2: a word start is always followed by its second half
      a_r2_word_alternates: assert property (@(posedge clk_fr)
        disable iff (rst) (new_word && !rst) |=> !new_word);
    end else if (MODE == SER_FULL) begin : g_full
      logic [2*WIDTH:0] unused_fr;
      assign unused_fr = {b2, b3, tog_i};
      assign new_word  = 1'b1;
      assign nxt_hi    = b0;
      assign nxt_lo    = b1;
    end else begin : g_simple
      logic [3*WIDTH:0] unused_fr;
      assign unused_fr = {b1, b2, b3, tog_i};
      assign new_word  = 1'b1;
      assign nxt_hi    = b0;
      assign nxt_lo    = b0;
    end
  endgenerate

  always_ff @(posedge clk_fr or negedge aclr_n or negedge apre_n) begin
    if (!aclr_n) begin
      hi_q   <= '0;
      lo_pos <= '0;
    end else if (!apre_n) begin
      hi_q   <= '1;
      lo_pos <= '1;
    end else if (rst) begin
      hi_q   <= '0;
      lo_pos <= '0;
    end else begin
      hi_q   <= nxt_hi;
      lo_pos <= nxt_lo;
    end
  end

  // low-phase bit retimed on the falling edge so it cannot glitch the pad
  always_ff @(negedge clk_fr or negedge aclr_n or negedge apre_n) begin
    if (!aclr_n)      lo_q <= '0;
    else if (!apre_n) lo_q <= '1;
    else if (rst)     lo_q <= '0;
    else              lo_q <= lo_pos;
  end
endmodule

// File: rtl/ddr_out_oe_path.sv
module ddr_out_oe_path #(
  parameter int WIDTH = 4
) (
  input  logic             clk_fr,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] oe_i,
  output logic [WIDTH-1:0] drv_en
);
  always_ff @(posedge clk_fr) begin
    if (rst)         drv_en <= '0;
    else if (load_i) drv_en <= oe_i;
  end

  // R3: drive enable holds between word starts
  a_r3_oe_held: assert property (@(posedge clk_fr)
    disable iff (rst) (!load_i && !rst) |=> $stable(drv_en));
endmodule

// File: rtl/ddr_out_serializer.sv
module ddr_out_serializer
  import ddr_out_pkg::*;
#(
  parameter int        WIDTH = 4,
  parameter ser_mode_e MODE  = SER_HALF
) (
  input  logic                   clk_hr,
  input  logic                   clk_fr,
  input  logic                   rst,
  input  logic                   aclr_n,
  input  logic                   apre_n,
  input  logic [WIDTH*LANES-1:0] din,
  input  logic [WIDTH-1:0]       oe,
  output logic [WIDTH-1:0]       pad_o,
  output logic [WIDTH-1:0]       pad_oe
);
  logic [WIDTH*LANES-1:0] word_hr;
  logic [WIDTH-1:0]       oe_hr;
  logic                   tog_hr;
  logic [WIDTH-1:0]       hi_q, lo_q;
  logic                   new_word;

  ddr_out_hr_stage #(.WIDTH(WIDTH), .MODE(MODE)) u_hr (
    .clk_hr (clk_hr),
    .rst    (rst),
    .din    (din),
    .oe_in  (oe),
    .word_q (word_hr),
    .oe_q   (oe_hr),
    .tog_q  (tog_hr)
  );

  ddr_out_fr_stage #(.WIDTH(WIDTH), .MODE(MODE)) u_fr (
    .clk_fr   (clk_fr),
    .rst      (rst),
    .aclr_n   (aclr_n),
    .apre_n   (apre_n),
    .word_i   (word_hr),
    .tog_i    (tog_hr),
    .hi_q     (hi_q),
    .lo_q     (lo_q),
    .new_word (new_word)
  );

  ddr_out_oe_path #(.WIDTH(WIDTH)) u_oe (
    .clk_fr (clk_fr),
    .rst    (rst),
    .load_i (new_word),
    .oe_i   (oe_hr),
    .drv_en (pad_oe)
  );

  // DDR output selector: high phase carries hi_q, low phase lo_q
  always_comb pad_o = clk_fr ? hi_q : lo_q;

  // R4: clear forces the pads low
  a_r4_clear_low: assert property (@(posedge clk_fr)
    disable iff (rst) !aclr_n |-> (pad_o == '0));

  // R5: preset forces the pads high when clear is idle
  a_r5_preset_high: assert property (@(posedge clk_fr)
    disable iff (rst) (aclr_n && !apre_n) |-> (pad_o == '1));
endmodule

// File: tb/ddr_out_serializer_bench.sv
module ddr_out_serializer_bench;
  import ddr_out_pkg::*;

  logic        clk_fr, clk_hr, rst, aclr_n, apre_n;
  logic [15:0] din;
  logic [3:0]  oe;
  logic [3:0]  pad_h, oe_h, pad_f, oe_f, pad_s, oe_s;
  int          checks = 0;
  int          errors = 0;

  ddr_out_serializer #(.WIDTH(4), .MODE(SER_HALF)) u_ddr_out_serializer (
    .clk_hr(clk_hr), .clk_fr(clk_fr), .rst(rst), .aclr_n(aclr_n), .apre_n(apre_n),
    .din(din), .oe(oe), .pad_o(pad_h), .pad_oe(oe_h));

  ddr_out_serializer #(.WIDTH(4), .MODE(SER_FULL)) u_full (
    .clk_hr(clk_hr), .clk_fr(clk_fr), .rst(rst), .aclr_n(aclr_n), .apre_n(apre_n),
    .din(din), .oe(oe), .pad_o(pad_f), .pad_oe(oe_f));

  ddr_out_serializer #(.WIDTH(4), .MODE(SER_SIMPLE)) u_simple (
    .clk_hr(clk_hr), .clk_fr(clk_fr), .rst(rst), .aclr_n(aclr_n), .apre_n(apre_n),
    .din(din), .oe(oe), .pad_o(pad_s), .pad_oe(oe_s));

  // 125 MHz full-rate clock; half-rate clock toggles on its rising edges
  initial begin
    clk_fr = 1'b0;
    clk_hr = 1'b0;
    forever begin
      #4;
      clk_fr = ~clk_fr;
      if (clk_fr) clk_hr = ~clk_hr;
    end
  end

  function automatic logic [3:0] lane(input logic [15:0] w, input int k);
    return w[k*4 +: 4];
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic t_reset();
    rst = 1'b1; aclr_n = 1'b1; apre_n = 1'b1; din = 16'hFFFF; oe = 4'hF;
    repeat (4) @(posedge clk_hr);
    #2;
    check("R6 pad_o half", pad_h, 4'h0);
    check("R6 pad_oe half", oe_h, 4'h0);
    check("R6 pad_o full", pad_f, 4'h0);
    check("R6 pad_o simple", pad_s, 4'h0);
    #4;
    check("R6 pad_o half low phase", pad_h, 4'h0);
    check("R6 pad_oe full", oe_f, 4'h0);
    rst = 1'b0;
  endtask

  task automatic t_half_stream();
    logic [15:0] w [6] = '{16'hA5C3, 16'hFFFF, 16'h0000, 16'h1234, 16'h8421, 16'h5A0F};
    logic [3:0]  o [6] = '{4'hF, 4'h0, 4'h5, 4'hA, 4'hF, 4'h3};
    @(posedge clk_hr); #2 din = w[0]; oe = o[0];
    for (int j = 0; j <= 6; j++) begin
      @(posedge clk_hr);
      #2;
      if (j > 0) begin
        check("R2 bit2 of word", pad_h, lane(w[j-1], 2));
        check("R3 enable during bit2", oe_h, o[j-1]);
      end
      if (j + 1 < 6) begin din = w[j+1]; oe = o[j+1]; end
      #4;
      if (j > 0) begin
        check("R2 bit3 of word", pad_h, lane(w[j-1], 3));
        check("R3 enable during bit3", oe_h, o[j-1]);
      end
      #4;
      if (j < 6) begin
        check("R1 bit0 of word", pad_h, lane(w[j], 0));
        check("R3 enable during bit0", oe_h, o[j]);
      end
      #4;
      if (j < 6) begin
        check("R1 bit1 of word", pad_h, lane(w[j], 1));
        check("R3 enable during bit1", oe_h, o[j]);
      end
    end
  endtask

  task automatic t_full_stream();
    logic [15:0] w [5] = '{16'h3C96, 16'hF00F, 16'h0FF0, 16'h1357, 16'hECA8};
    logic [3:0]  o [5] = '{4'h1, 4'hE, 4'h0, 4'hF, 4'h6};
    @(posedge clk_fr); #2 din = w[0]; oe = o[0];
    for (int j = 0; j < 5; j++) begin
      @(posedge clk_fr);
      #2;
      check("R7 full high phase", pad_f, lane(w[j], 0));
      check("R7 full enable", oe_f, o[j]);
      if (j + 1 < 5) begin din = w[j+1]; oe = o[j+1]; end
      #4;
      check("R7 full low phase", pad_f, lane(w[j], 1));
    end
  endtask

  task automatic t_simple_stream();
    logic [15:0] w [4] = '{16'hFFF0, 16'h000F, 16'hEEE9, 16'h1116};
    @(posedge clk_fr); #2 din = w[0];
    for (int j = 0; j < 4; j++) begin
      @(posedge clk_fr);
      #2;
      check("R8 simple high phase", pad_s, lane(w[j], 0));
      if (j + 1 < 4) din = w[j+1];
      #4;
      check("R8 simple low phase lanes 1-3 ignored", pad_s, lane(w[j], 0));
    end
  endtask

  task automatic t_clear();
    din = 16'hFFFF; oe = 4'hF;
    @(posedge clk_fr); #1 aclr_n = 1'b0;
    #1;
    check("R4 clear immediate half", pad_h, 4'h0);
    check("R4 clear immediate full", pad_f, 4'h0);
    check("R4 clear immediate simple", pad_s, 4'h0);
    repeat (2) @(posedge clk_fr);
    #2 check("R4 clear held high phase", pad_h, 4'h0);
    #4 check("R4 clear held low phase", pad_h, 4'h0);
    apre_n = 1'b0;
    #1 check("R5 clear beats preset", pad_h, 4'h0);
    check("R5 clear beats preset full", pad_f, 4'h0);
    apre_n = 1'b1;
    #1 aclr_n = 1'b1;
  endtask

  task automatic t_preset();
    din = 16'h0000; oe = 4'h0;
    @(posedge clk_fr); #1 apre_n = 1'b0;
    #1;
    check("R5 preset immediate half", pad_h, 4'hF);
    check("R5 preset immediate simple", pad_s, 4'hF);
    #4 check("R5 preset low phase", pad_h, 4'hF);
    repeat (2) @(posedge clk_fr);
    #2 check("R5 preset held over edges", pad_f, 4'hF);
    apre_n = 1'b1;
  endtask

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    t_reset();
    t_half_stream();
    t_full_stream();
    t_simple_stream();
    t_clear();
    t_preset();
    repeat (4) @(posedge clk_fr);
    report();
  end
endmodule